// File: doc/BRIEF.md
# Multiprocessor-Format Asynchronous Serial Transmitter

This block serialises one byte at a time onto an asynchronous line. Software places a byte in a holding register. It then clears the data-empty flag to queue that byte. When the transmitter finds the flag cleared, it copies the byte and the current frame settings into a shift register and sets the flag again. From the next baud tick it shifts out a frame: a low start bit, seven or eight data bits with the least significant bit first, a multiprocessor flag bit taken from a software control input, and one or two high stop bits.

At the start of the last stop bit the transmitter looks at the data-empty flag again. If software has queued another byte by then, that byte is loaded at once and its start bit follows the stop bit with no idle gap. If nothing is queued, the transmit-end flag is set and the line stays high (marking) until a new byte arrives. Each flag drives its own interrupt request, and each request has its own enable. The baud enable tick comes from outside the block and is one clock cycle wide per bit period.

Top module: `mpx_serial_tx`

## Requirements
- R1: After reset the line output is 1, the data-empty flag is 1 and the transmit-end flag is 1.
- R2: While the transmitter is idle and the data-empty flag reads 0, the holding register is copied on the next clock edge and the data-empty flag returns to 1 on that edge.
- R3: The start bit (0) appears on the first baud tick after the copy, and every later bit of the frame changes only on a baud tick, so each bit lasts one tick period.
- R4: In 8-bit mode the line carries, in order: 0, data bits 0 through 7, the multiprocessor bit, then the stop bit(s) at 1.
- R5: In 7-bit mode (`short_len` = 1), holding register bit 7 is ignored and the multiprocessor bit comes directly after data bit 6.
- R6: With `two_stop` = 0 one stop bit is sent, and with `two_stop` = 1 two are sent; the end decision is taken at the start of the last stop bit.
- R7: If the data-empty flag is 0 when the last stop bit starts, the next byte is loaded then, the transmit-end flag stays 0, and its start bit follows the last stop bit with no idle bit in between.
- R8: If the data-empty flag is 1 when the last stop bit starts, the transmit-end flag is set on that tick, and after the stop bit the line stays at 1.
- R9: `txde_irq` is 1 exactly when the data-empty flag is 1 and `txde_ie` is 1.
- R10: `tend_irq` is 1 exactly when the transmit-end flag is 1 and `tend_ie` is 1.
- R11: `short_len`, `two_stop` and `mp_bit` are sampled when a byte is copied; changing them during a frame does not change that frame.
- R12: Pulsing `empty_clr` clears the transmit-end flag on the same edge that clears the data-empty flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| baud_tick | input | 1 | One-cycle enable per bit period |
| hold_we | input | 1 | Write strobe for the holding register |
| hold_wdata | input | 8 | Byte written into the holding register |
| empty_clr | input | 1 | Clears the data-empty flag to queue the held byte |
| mp_bit | input | 1 | Value of the multiprocessor bit for the next frame |
| short_len | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| two_stop | input | 1 | 1 selects two stop bits, 0 selects one |
| txde_ie | input | 1 | Enable for the data-empty interrupt request |
| tend_ie | input | 1 | Enable for the transmit-end interrupt request |
| tx_line | output | 1 | Serial line output |
| data_empty | output | 1 | Data-empty flag |
| tx_end | output | 1 | Transmit-end flag |
| txde_irq | output | 1 | Data-empty interrupt request |
| tend_irq | output | 1 | Transmit-end interrupt request |

## Verification
A wrong bit counter or a wrong sequencer state shows on `tx_line` within the frame where it happens. The bit stream, recorded once per baud tick, then has the wrong length, a shifted multiprocessor bit, or a spurious or missing start bit. A wrong end decision shows on `tx_end` one tick later, at the start of the last stop bit. There are two symptoms: a gap bit between chained frames, or a transmit-end flag that rises while a byte is queued. Flag errors show on `data_empty` and the interrupt outputs within two clock cycles of a clear pulse.

// File: rtl/mpx_tx_pkg.sv
package mpx_tx_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ARMED = 2'd1,
    SEQ_SEND  = 2'd2
  } seq_state_e;

  function automatic int unsigned frame_bits_max(int unsigned data_w, int unsigned max_stop);
    return data_w + 2 + max_stop;
  endfunction

endpackage

// File: rtl/mpx_tx_rst_sync.sv
module mpx_tx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/mpx_tx_framer.sv
module mpx_tx_framer #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned MAX_STOP = 2,
  parameter int unsigned FRAME_W  = DATA_W + 2 + MAX_STOP,
  parameter int unsigned CNT_W    = $clog2(FRAME_W + 1)
) (
  input  logic [DATA_W-1:0]  data_i,
  input  logic               mp_i,
  input  logic               short_i,
  input  logic               two_stop_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [CNT_W-1:0]   nbits_o
);

  localparam int unsigned LONG_LEN  = DATA_W;
  localparam int unsigned SHORT_LEN = DATA_W - 1;

  logic [CNT_W-1:0] len;
  logic [CNT_W-1:0] mp_pos;

  assign len    = short_i ? CNT_W'(SHORT_LEN) : CNT_W'(LONG_LEN);
  assign mp_pos = len + CNT_W'(1);

  // Position 0 is the start bit; data, flag bit and stop fill follow.
  assign frame_o[0] = 1'b0;

  for (genvar k = 1; k < FRAME_W; k++) begin : g_bit
    if (k <= DATA_W) begin : g_data
      assign frame_o[k] = (CNT_W'(k) <= len)    ? data_i[k-1] :
                          (CNT_W'(k) == mp_pos) ? mp_i        : 1'b1;
    end else begin : g_tail
      assign frame_o[k] = (CNT_W'(k) == mp_pos) ? mp_i : 1'b1;
    end
  end

  assign nbits_o = len + CNT_W'(2) + (two_stop_i ? CNT_W'(MAX_STOP) : CNT_W'(1));

endmodule

// File: rtl/mpx_tx_shifter.sv
module mpx_tx_shifter #(
  parameter int unsigned FRAME_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               shift_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               line_o
);

  logic [FRAME_W-1:0] frame_q;
  logic [FRAME_W-1:0] frame_d;
  logic               line_q;
  logic               line_d;
  logic               upd_en;

  always_comb begin
    frame_d = frame_q;
    line_d  = line_q;
    if (shift_i) begin
      line_d  = frame_q[0];
      frame_d = {1'b1, frame_q[FRAME_W-1:1]};
    end
    if (load_i) begin
      frame_d = frame_i;
    end
  end

  assign upd_en = load_i | shift_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '1;
      line_q  <= 1'b1;
    end else if (upd_en) begin
      frame_q <= frame_d;
      line_q  <= line_d;
    end
  end

  assign line_o = line_q;

endmodule

// File: rtl/mpx_tx_seq.sv
module mpx_tx_seq
  import mpx_tx_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             empty_i,
  input  logic [CNT_W-1:0] nbits_i,
  output logic             load_o,
  output logic             shift_o,
  output logic             tend_set_o,
  output seq_state_e       state_o
);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    load_o     = 1'b0;
    shift_o    = 1'b0;
    tend_set_o = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (!empty_i) begin
          load_o  = 1'b1;
          cnt_d   = nbits_i;
          state_d = SEQ_ARMED;
        end
      end
      SEQ_ARMED: begin
        // Line keeps its level (marking or final stop) until the tick.
        if (tick_i) begin
          shift_o = 1'b1;
          cnt_d   = cnt_q - CNT_W'(1);
          state_d = SEQ_SEND;
        end
      end
      SEQ_SEND: begin
        if (tick_i) begin
          shift_o = 1'b1;
          if (cnt_q == '0) begin
            state_d = SEQ_IDLE;
          end else if (cnt_q == CNT_W'(1)) begin
            // This tick starts the last stop bit: chain or finish.
            if (!empty_i) begin
              load_o  = 1'b1;
              cnt_d   = nbits_i;
              state_d = SEQ_ARMED;
            end else begin
              tend_set_o = 1'b1;
              cnt_d      = '0;
            end
          end else begin
            cnt_d = cnt_q - CNT_W'(1);
          end
        end
      end
      default: begin
        state_d = SEQ_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/mpx_tx_flags.sv
module mpx_tx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic clr_i,
  input  logic tend_set_i,
  input  logic txde_ie_i,
  input  logic tend_ie_i,
  output logic empty_o,
  output logic tend_o,
  output logic txde_irq_o,
  output logic tend_irq_o
);

  logic empty_q, empty_d;
  logic tend_q, tend_d;

  always_comb begin
    empty_d = empty_q;
    if (load_i) begin
      empty_d = 1'b1;
    end else if (clr_i) begin
      empty_d = 1'b0;
    end
  end

  always_comb begin
    tend_d = tend_q;
    if (clr_i) begin
      tend_d = 1'b0;
    end else if (tend_set_i) begin
      tend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
      tend_q  <= 1'b1;
    end else begin
      empty_q <= empty_d;
      tend_q  <= tend_d;
    end
  end

  assign empty_o    = empty_q;
  assign tend_o     = tend_q;
  assign txde_irq_o = empty_q & txde_ie_i;
  assign tend_irq_o = tend_q & tend_ie_i;

endmodule

// File: rtl/mpx_serial_tx.sv
module mpx_serial_tx
  import mpx_tx_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned MAX_STOP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              hold_we,
  input  logic [DATA_W-1:0] hold_wdata,
  input  logic              empty_clr,
  input  logic              mp_bit,
  input  logic              short_len,
  input  logic              two_stop,
  input  logic              txde_ie,
  input  logic              tend_ie,
  output logic              tx_line,
  output logic              data_empty,
  output logic              tx_end,
  output logic              txde_irq,
  output logic              tend_irq
);

  localparam int unsigned FRAME_W = frame_bits_max(DATA_W, MAX_STOP);
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

  logic               rst_sync_n;
  logic [DATA_W-1:0]  hold_q;
  logic [FRAME_W-1:0] frame_w;
  logic [CNT_W-1:0]   nbits_w;
  logic               seq_load;
  logic               seq_shift;
  logic               seq_tend_set;
  seq_state_e         seq_state;

  mpx_tx_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sync_n)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hold_q <= '0;
    end else if (hold_we) begin
      hold_q <= hold_wdata;
    end
  end

  mpx_tx_framer #(
    .DATA_W   (DATA_W),
    .MAX_STOP (MAX_STOP),
    .FRAME_W  (FRAME_W),
    .CNT_W    (CNT_W)
  ) u_framer (
    .data_i     (hold_q),
    .mp_i       (mp_bit),
    .short_i    (short_len),
    .two_stop_i (two_stop),
    .frame_o    (frame_w),
    .nbits_o    (nbits_w)
  );

  mpx_tx_seq #(.CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .tick_i     (baud_tick),
    .empty_i    (data_empty),
    .nbits_i    (nbits_w),
    .load_o     (seq_load),
    .shift_o    (seq_shift),
    .tend_set_o (seq_tend_set),
    .state_o    (seq_state)
  );

  mpx_tx_shifter #(.FRAME_W(FRAME_W)) u_shifter (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load_i  (seq_load),
    .shift_i (seq_shift),
    .frame_i (frame_w),
    .line_o  (tx_line)
  );

  mpx_tx_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .load_i     (seq_load),
    .clr_i      (empty_clr),
    .tend_set_i (seq_tend_set),
    .txde_ie_i  (txde_ie),
    .tend_ie_i  (tend_ie),
    .empty_o    (data_empty),
    .tend_o     (tx_end),
    .txde_irq_o (txde_irq),
    .tend_irq_o (tend_irq)
  );

endmodule

// File: rtl/mpx_serial_tx_chk.sv
module mpx_serial_tx_chk
  import mpx_tx_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       clr,
  input logic       empty,
  input logic       tend,
  input logic       line,
  input logic       load,
  input seq_state_e state
);

  // R8: the line is marking whenever the sequencer is idle
  p_idle_mark_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_IDLE) |-> line);

  // R8: transmit-end rises only while a stop bit is on the line
  p_tend_on_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tend) |-> line);

  // R2: a copy happens only on a cleared flag and sets it again
  p_load_needs_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !empty);

  p_load_sets_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> empty);

  // R3: the tick that leaves the armed state drives the start bit
  p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_ARMED && tick) |=> !line);

  // R12: a clear pulse always leaves transmit-end low
  p_clr_drops_tend_r12: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !tend);

endmodule

bind mpx_serial_tx mpx_serial_tx_chk u_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .tick  (baud_tick),
  .clr   (empty_clr),
  .empty (data_empty),
  .tend  (tx_end),
  .line  (tx_line),
  .load  (seq_load),
  .state (seq_state)
);

// File: tb/mpx_serial_tx_tb.sv
`timescale 1ns/100ps
module mpx_serial_tx_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       baud_tick = 1'b0;
  logic       hold_we;
  logic [7:0] hold_wdata;
  logic       empty_clr;
  logic       mp_bit;
  logic       short_len;
  logic       two_stop;
  logic       txde_ie;
  logic       tend_ie;
  logic       tx_line;
  logic       data_empty;
  logic       tx_end;
  logic       txde_irq;
  logic       tend_irq;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  logic rec [0:2047];
  int rec_n    = 0;
  int tick_div = 0;

  always #2.5 clk = ~clk;

  mpx_serial_tx u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_tick  (baud_tick),
    .hold_we    (hold_we),
    .hold_wdata (hold_wdata),
    .empty_clr  (empty_clr),
    .mp_bit     (mp_bit),
    .short_len  (short_len),
    .two_stop   (two_stop),
    .txde_ie    (txde_ie),
    .tend_ie    (tend_ie),
    .tx_line    (tx_line),
    .data_empty (data_empty),
    .tx_end     (tx_end),
    .txde_irq   (txde_irq),
    .tend_irq   (tend_irq)
  );

  // Record the line once per tick, then advance the tick divider (period 4).
  always @(negedge clk) begin
    if (baud_tick && rec_n < 2048) begin
      rec[rec_n] = tx_line;
      rec_n++;
    end
    tick_div  = (tick_div == 3) ? 0 : tick_div + 1;
    baud_tick = (tick_div == 3);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int frame_len(bit short, bit two);
    return (short ? 7 : 8) + 2 + (two ? 2 : 1);
  endfunction

  function automatic logic exp_bit(logic [7:0] d, bit short, bit mp, int k);
    int len = short ? 7 : 8;
    if (k == 0) return 1'b0;
    if (k <= len) return d[k-1];
    if (k == len + 1) return mp;
    return 1'b1;
  endfunction

  task automatic check_frame(string req, int mark, logic [7:0] d, bit short, bit two, bit mp);
    logic [15:0] a = '0;
    logic [15:0] e = '0;
    for (int k = 0; k < frame_len(short, two); k++) begin
      a[k] = rec[mark + k];
      e[k] = exp_bit(d, short, mp, k);
    end
    check(req, "frame bits", {16'h0, a}, {16'h0, e});
  endtask

  task automatic wait_recs(int n);
    while (rec_n < n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic sync_tick();
    int r = rec_n;
    do begin
      @(negedge clk);
      #1;
    end while (rec_n == r);
  endtask

  task automatic write_hold(logic [7:0] d, bit short, bit two, bit mp);
    @(negedge clk);
    #1;
    hold_we = 1'b1; hold_wdata = d;
    short_len = short; two_stop = two; mp_bit = mp;
    @(negedge clk);
    #1;
    hold_we = 1'b0;
  endtask

  // Queue a byte right after a tick; returns the index of its start bit.
  task automatic start_frame(logic [7:0] d, bit short, bit two, bit mp, output int mark);
    write_hold(d, short, two, mp);
    sync_tick();
    mark = rec_n;
    empty_clr = 1'b1;
    @(negedge clk);
    #1;
    empty_clr = 1'b0;
    check("R12", "tend after clear", 32'(tx_end), 32'd0);
    check("R2", "empty after clear", 32'(data_empty), 32'd0);
    check("R9", "txde irq while full", 32'(txde_irq), 32'd0);
    @(negedge clk);
    #1;
    check("R2", "empty after copy", 32'(data_empty), 32'd1);
  endtask

  task automatic t_reset();
    check("R1", "line", 32'(tx_line), 32'd1);
    check("R1", "empty", 32'(data_empty), 32'd1);
    check("R1", "tend", 32'(tx_end), 32'd1);
  endtask

  task automatic t_irq_masks();
    txde_ie = 1'b0; tend_ie = 1'b0;
    @(negedge clk);
    #1;
    check("R9", "txde irq masked", 32'(txde_irq), 32'd0);
    check("R10", "tend irq masked", 32'(tend_irq), 32'd0);
    txde_ie = 1'b1; tend_ie = 1'b1;
    @(negedge clk);
    #1;
    check("R9", "txde irq enabled", 32'(txde_irq), 32'd1);
    check("R10", "tend irq enabled", 32'(tend_irq), 32'd1);
  endtask

  task automatic t_frame8();
    int m;
    start_frame(8'hA5, 1'b0, 1'b0, 1'b1, m);
    wait_recs(m + 13);
    check("R3", "marking before start", 32'(rec[m-1]), 32'd1);
    check("R3", "start on first tick", 32'(rec[m]), 32'd0);
    check_frame("R4", m, 8'hA5, 1'b0, 1'b0, 1'b1);
    check("R8", "marking after stop", 32'(rec[m+11]), 32'd1);
    check("R8", "tend set", 32'(tx_end), 32'd1);
    check("R10", "tend irq", 32'(tend_irq), 32'd1);
  endtask

  task automatic t_frame7();
    int m;
    start_frame(8'hC3, 1'b1, 1'b0, 1'b0, m);
    wait_recs(m + 12);
    check_frame("R5", m, 8'hC3, 1'b1, 1'b0, 1'b0);
    check("R5", "flag bit after d6", 32'(rec[m+8]), 32'd0);
  endtask

  task automatic t_two_stop();
    int m;
    start_frame(8'h3C, 1'b0, 1'b1, 1'b1, m);
    wait_recs(m + 11);
    check("R6", "tend low in first stop", 32'(tx_end), 32'd0);
    wait_recs(m + 12);
    check("R6", "tend set at last stop", 32'(tx_end), 32'd1);
    wait_recs(m + 14);
    check_frame("R6", m, 8'h3C, 1'b0, 1'b1, 1'b1);
    check("R8", "marking after two stops", 32'(rec[m+13]), 32'd1);
  endtask

  task automatic t_chain();
    int m;
    start_frame(8'h11, 1'b0, 1'b0, 1'b0, m);
    wait_recs(m + 3);
    write_hold(8'h6E, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    #1;
    empty_clr = 1'b1;
    @(negedge clk);
    #1;
    empty_clr = 1'b0;
    wait_recs(m + 11);
    check("R7", "tend low when chaining", 32'(tx_end), 32'd0);
    check("R7", "next byte taken", 32'(data_empty), 32'd1);
    wait_recs(m + 11 + 12);
    check_frame("R11", m, 8'h11, 1'b0, 1'b0, 1'b0);
    check_frame("R7", m + 11, 8'h6E, 1'b1, 1'b1, 1'b1);
    check("R8", "tend after chained end", 32'(tx_end), 32'd1);
  endtask

  task automatic t_cfg_latch();
    int m;
    start_frame(8'h96, 1'b0, 1'b0, 1'b1, m);
    short_len = 1'b1; two_stop = 1'b1; mp_bit = 1'b0;
    wait_recs(m + 13);
    check_frame("R11", m, 8'h96, 1'b0, 1'b0, 1'b1);
    check("R11", "one stop only", 32'(rec[m+11]), 32'd1);
  endtask

  initial begin
    rst_n = 1'b0; hold_we = 1'b0; hold_wdata = '0; empty_clr = 1'b0;
    mp_bit = 1'b0; short_len = 1'b0; two_stop = 1'b0;
    txde_ie = 1'b1; tend_ie = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    t_reset();
    t_irq_masks();
    t_frame8();
    t_frame7();
    t_two_stop();
    t_chain();
    t_cfg_latch();
    repeat (8) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule